// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models a small parallel NOR-style flash device that sits behind a single-cycle synchronous memory bus. The array is built from registers and is split into equal sectors. Software controls the device by writing command bytes as ordinary bus data. The low byte of each write selects what happens next: program one word, erase a sector, run a buffered burst of writes, lock or unlock, read the status register, read the identifier words, or read a small query table. A one-byte status register holds a ready flag in bit 7. Reads are registered, and their source depends on the currently latched mode.

Two pieces of state control the block: a write phase and a latched mode. Together they decide how the next write is interpreted and where a read is steered.

The phase machine has four states:

- `PH_IDLE` decodes a command byte.
- `PH_ARG` takes the second write of a two-write command.
- `PH_DATA` takes the data words of a buffered write.
- `PH_CONFIRM` waits for the confirm byte that closes a buffered write.

The transitions are:

- **arm**: `PH_IDLE` to `PH_ARG`, on a program, erase, lock, query or buffered-write command.
- **count**: `PH_ARG` to `PH_DATA`, when the buffered-write count is taken.
- **last**: `PH_DATA` to `PH_CONFIRM`, when the count reaches zero.
- **finish**: `PH_ARG` or `PH_CONFIRM` to `PH_IDLE`, on a valid completion.
- **abort**: any phase to `PH_IDLE` with the mode set to array, on an unknown or unexpected write.

Top module: `pflash_cmd_if`

## Requirements
- R1: After reset the mode is array read and status is 0x00. `rdata` is 0, and every word of the array reads 0xFFFF.
- R2: A write whose low byte is 0x10 or 0x40 arms a program. The next write stores its 16-bit data at word `addr>>1`, sets status bit 7 and returns to array mode.
- R3: A write whose low byte is 0x20 fills every word of the sector holding `addr>>1` with 0xFFFF at once and sets status bit 7. The sector is 16 words (32 bytes). A following 0xD0 returns to idle with status reads still selected. Any other second write returns to array mode.
- R4: After 0xE8, the next write gives a count N, and the following N+1 writes store data at their own word addresses. A write of 0xD0 then returns to idle with status reads selected. Any other value at that point returns to array mode.
- R5: After 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and keeps status reads selected. Any other second write returns to array mode.
- R6: While the mode is erase, lock, status (selected by 0x70) or buffered write, reads return `{8'h00, status}`.
- R7: After 0x90, reads use index `addr>>1`. Index 0 returns the manufacturer code (0x0089), index 1 returns the device code (0x0018), and any other index returns 0.
- R8: After 0x98, reads return a table byte at index `addr>>1`, zero-extended. Indices 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59, index 0x27 holds log2 of the array size in bytes (8), and indices above 0x36 read 0. The next write returns to array mode.
- R9: A write whose low byte is 0x50 in the idle phase zeroes status and selects array mode.
- R10: In the idle phase, 0xFF, 0x00 or any code not listed in R2–R9 selects array mode.
- R11: `rdata` is updated only on a clock edge where `rd_en` is high, and it is valid after that edge. It holds its value otherwise.
- R12: Only bits 7:0 of `wdata` are decoded as a command. Upper bits do not change the decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address |
| wdata | input | 16 | Write data or command |
| rdata | output | 16 | Registered read data |

## Verification
The checker watches the cycle-level phase and mode rules on every clock edge. These rules are:

- a program completing into array mode with ready set;
- an erase confirm keeping status reads selected;
- data and confirm phases existing only under a buffered write;
- clear-status zeroing the register;
- a bad confirm aborting;
- status-mode reads returning the status value;
- `rdata` holding when no read is requested.

Array contents need the bench's scenarios: sector-wide erase bounds, buffered-write counts, identifier and query indexing, and the array staying untouched after aborted sequences. The bench checks these at the ports against expected values taken from the requirements.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARG,
        PH_DATA,
        PH_CONFIRM
    } phase_t;

    typedef enum logic [2:0] {
        MD_ARRAY,
        MD_PROG,
        MD_ERASE,
        MD_LOCK,
        MD_STATUS,
        MD_IDENT,
        MD_QUERY,
        MD_BUFWR
    } mode_t;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUFWR    = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;

    localparam int RDY_BIT = 7;

endpackage

// File: rtl/pflash_seq.sv
// Command-sequence decoder: write phase, latched mode, status and burst count.
module pflash_seq
    import pflash_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       op,
    input  logic [CNT_W-1:0] cnt_in,
    output phase_t           phase,
    output mode_t            mode,
    output logic [7:0]       status,
    output logic             arr_we,
    output logic             arr_erase
);

    phase_t           nxt_phase;
    mode_t            nxt_mode;
    logic [7:0]       nxt_status;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] nxt_count;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            mode    <= MD_ARRAY;
            status  <= 8'h00;
            count_q <= '0;
        end else begin
            phase   <= nxt_phase;
            mode    <= nxt_mode;
            status  <= nxt_status;
            count_q <= nxt_count;
        end
    end

    // Next state and array strobes
    always_comb begin
        nxt_phase  = phase;
        nxt_mode   = mode;
        nxt_status = status;
        nxt_count  = count_q;
        arr_we     = 1'b0;
        arr_erase  = 1'b0;
        if (wr_en) begin
            unique case (phase)
                PH_IDLE: begin
                    case (op)
                        OP_PROG_A, OP_PROG_B: begin
                            nxt_phase = PH_ARG;
                            nxt_mode  = MD_PROG;
                        end
                        OP_ERASE: begin
                            arr_erase           = 1'b1;
                            nxt_status[RDY_BIT] = 1'b1;
                            nxt_phase           = PH_ARG;
                            nxt_mode            = MD_ERASE;
                        end
                        OP_CLEAR: begin
                            nxt_status = 8'h00;
                            nxt_mode   = MD_ARRAY;
                        end
                        OP_LOCK: begin
                            nxt_phase = PH_ARG;
                            nxt_mode  = MD_LOCK;
                        end
                        OP_STATUS: nxt_mode = MD_STATUS;
                        OP_IDENT:  nxt_mode = MD_IDENT;
                        OP_QUERY: begin
                            nxt_phase = PH_ARG;
                            nxt_mode  = MD_QUERY;
                        end
                        OP_BUFWR: begin
                            nxt_status[RDY_BIT] = 1'b1;
                            nxt_phase           = PH_ARG;
                            nxt_mode            = MD_BUFWR;
                        end
                        default: begin
                            nxt_phase = PH_IDLE;
                            nxt_mode  = MD_ARRAY;
                        end
                    endcase
                end
                PH_ARG: begin
                    case (mode)
                        MD_PROG: begin
                            arr_we              = 1'b1;
                            nxt_status[RDY_BIT] = 1'b1;
                            nxt_phase           = PH_IDLE;
                            nxt_mode            = MD_ARRAY;
                        end
                        MD_ERASE: begin
                            nxt_phase = PH_IDLE;
                            if (op == OP_CONFIRM) begin
                                nxt_status[RDY_BIT] = 1'b1;
                            end else begin
                                nxt_mode = MD_ARRAY;
                            end
                        end
                        MD_LOCK: begin
                            nxt_phase = PH_IDLE;
                            if (op == OP_CONFIRM || op == OP_LOCK_ALT) begin
                                nxt_status[RDY_BIT] = 1'b1;
                            end else begin
                                nxt_mode = MD_ARRAY;
                            end
                        end
                        MD_BUFWR: begin
                            nxt_count = cnt_in;
                            nxt_phase = PH_DATA;
                        end
                        default: begin
                            nxt_phase = PH_IDLE;
                            nxt_mode  = MD_ARRAY;
                        end
                    endcase
                end
                PH_DATA: begin
                    arr_we              = 1'b1;
                    nxt_status[RDY_BIT] = 1'b1;
                    if (count_q == '0) begin
                        nxt_phase = PH_CONFIRM;
                    end else begin
                        nxt_count = count_q - CNT_W'(1);
                    end
                end
                PH_CONFIRM: begin
                    nxt_phase = PH_IDLE;
                    if (op == OP_CONFIRM) begin
                        nxt_status[RDY_BIT] = 1'b1;
                    end else begin
                        nxt_mode = MD_ARRAY;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pflash_store.sv
// Register array with a one-word write port and a whole-sector erase.
module pflash_store #(
    parameter int DATA_W     = 16,
    parameter int WORDS      = 128,
    parameter int SECT_WORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     erase,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);

    localparam int WA_W   = $clog2(WORDS);
    localparam int SEC_SH = $clog2(SECT_WORDS);
    localparam int SW     = WA_W - SEC_SH;

    logic [DATA_W-1:0] cell_rd [WORDS];
    logic [SW-1:0]     tgt_sect;

    assign tgt_sect = waddr[WA_W-1:SEC_SH];

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_cell
        localparam int SECT_OF = gi / SECT_WORDS;
        logic [DATA_W-1:0] cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (erase && tgt_sect == SW'(SECT_OF)) begin
                cell_q <= '1;
            end else if (we && waddr == WA_W'(gi)) begin
                cell_q <= wdata;
            end
        end

        assign cell_rd[gi] = cell_q;
    end

    assign rdata = cell_rd[raddr];

endmodule

// File: rtl/pflash_query.sv
// Fixed query table, computed from the geometry parameters.
module pflash_query #(
    parameter int ADDR_W      = 8,
    parameter int TOTAL_BYTES = 256,
    parameter int SECT_BYTES  = 32,
    parameter int SECTORS     = 8,
    parameter int QRY_LEN     = 'h36
) (
    input  logic [ADDR_W-1:0] idx,
    output logic [7:0]        qbyte
);

    localparam int SIZE_LOG2 = $clog2(TOTAL_BYTES);
    localparam int BUF_LOG2  = $clog2(SECT_BYTES);
    localparam int LAST_SECT = SECTORS - 1;

    always_comb begin
        qbyte = 8'h00;
        if (int'(idx) <= QRY_LEN) begin
            case (int'(idx))
                'h10: qbyte = 8'h51;
                'h11: qbyte = 8'h52;
                'h12: qbyte = 8'h59;
                'h13: qbyte = 8'h01;
                'h15: qbyte = 8'h31;
                'h1B: qbyte = 8'h45;
                'h1C: qbyte = 8'h55;
                'h1F: qbyte = 8'h07;
                'h20: qbyte = 8'h07;
                'h21: qbyte = 8'h0A;
                'h23: qbyte = 8'h04;
                'h24: qbyte = 8'h04;
                'h25: qbyte = 8'h04;
                'h27: qbyte = 8'(SIZE_LOG2);
                'h28: qbyte = 8'h02;
                'h2A: qbyte = 8'(BUF_LOG2);
                'h2C: qbyte = 8'h01;
                'h2D: qbyte = 8'(LAST_SECT);
                'h2E: qbyte = 8'(LAST_SECT >> 8);
                'h2F: qbyte = 8'(SECT_BYTES >> 8);
                'h30: qbyte = 8'(SECT_BYTES >> 16);
                'h31: qbyte = 8'h50;
                'h32: qbyte = 8'h52;
                'h33: qbyte = 8'h49;
                'h34: qbyte = 8'h31;
                'h35: qbyte = 8'h31;
                default: qbyte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/pflash_cmd_if.sv
// Top: ties the decoder, the array and the query table to a registered read path.
module pflash_cmd_if
    import pflash_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 8,
    parameter int          SECT_WORDS = 16,
    parameter logic [15:0] MANUF_ID   = 16'h0089,
    parameter logic [15:0] DEVICE_ID  = 16'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int BYTES   = DATA_W / 8;
    localparam int BYTE_SH = $clog2(BYTES);
    localparam int WORDS   = (1 << ADDR_W) / BYTES;
    localparam int WA_W    = ADDR_W - BYTE_SH;
    localparam int SECTORS = WORDS / SECT_WORDS;

    phase_t            phase_q;
    mode_t             mode_q;
    logic [7:0]        status_q;
    logic              arr_we;
    logic              arr_erase;
    logic [WA_W-1:0]   word_addr;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] arr_word;
    logic [7:0]        qry_byte;
    logic [DATA_W-1:0] rd_mux;

    assign word_addr = addr[ADDR_W-1:BYTE_SH];
    assign idx       = addr >> BYTE_SH;

    pflash_seq #(
        .CNT_W (WA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .op        (wdata[7:0]),
        .cnt_in    (wdata[WA_W-1:0]),
        .phase     (phase_q),
        .mode      (mode_q),
        .status    (status_q),
        .arr_we    (arr_we),
        .arr_erase (arr_erase)
    );

    pflash_store #(
        .DATA_W     (DATA_W),
        .WORDS      (WORDS),
        .SECT_WORDS (SECT_WORDS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .erase (arr_erase),
        .waddr (word_addr),
        .wdata (wdata),
        .raddr (word_addr),
        .rdata (arr_word)
    );

    pflash_query #(
        .ADDR_W      (ADDR_W),
        .TOTAL_BYTES (1 << ADDR_W),
        .SECT_BYTES  (SECT_WORDS * BYTES),
        .SECTORS     (SECTORS)
    ) u_query (
        .idx   (idx),
        .qbyte (qry_byte)
    );

    // Read source chosen by the latched mode
    always_comb begin
        unique case (mode_q)
            MD_ARRAY, MD_PROG: rd_mux = arr_word;
            MD_ERASE, MD_LOCK, MD_STATUS, MD_BUFWR: rd_mux = DATA_W'(status_q);
            MD_IDENT: begin
                if (idx == '0) begin
                    rd_mux = DATA_W'(MANUF_ID);
                end else if (idx == ADDR_W'(1)) begin
                    rd_mux = DATA_W'(DEVICE_ID);
                end else begin
                    rd_mux = '0;
                end
            end
            MD_QUERY: rd_mux = DATA_W'(qry_byte);
        endcase
    end

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pflash_cmd_if_chk.sv
module pflash_cmd_if_chk
    import pflash_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        op,
    input logic [DATA_W-1:0] rdata,
    input phase_t            phase_q,
    input mode_t             mode_q,
    input logic [7:0]        status_q
);

    assert_prog_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_ARG && mode_q == MD_PROG)
        |=> (status_q[RDY_BIT] && phase_q == PH_IDLE && mode_q == MD_ARRAY));

    assert_erase_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_ARG && mode_q == MD_ERASE && op == OP_CONFIRM)
        |=> (phase_q == PH_IDLE && mode_q == MD_ERASE && status_q[RDY_BIT]));

    assert_burst_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA || phase_q == PH_CONFIRM) |-> (mode_q == MD_BUFWR));

    assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (mode_q == MD_ERASE || mode_q == MD_LOCK ||
                   mode_q == MD_STATUS || mode_q == MD_BUFWR))
        |=> (rdata == DATA_W'($past(status_q))));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_IDLE && op == OP_CLEAR)
        |=> (status_q == 8'h00 && mode_q == MD_ARRAY));

    assert_bad_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && phase_q == PH_CONFIRM && op != OP_CONFIRM)
        |=> (phase_q == PH_IDLE && mode_q == MD_ARRAY));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind pflash_cmd_if pflash_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .op       (wdata[7:0]),
    .rdata    (rdata),
    .phase_q  (phase_q),
    .mode_q   (mode_q),
    .status_q (status_q)
);

// File: tb/pflash_cmd_if_bench.sv
`timescale 1ns/1ps
module pflash_cmd_if_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pflash_cmd_if u_pflash_cmd_if (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // {is_read, addr, wdata, expected, requirement}
    localparam int NV = 68;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 8'h10, 16'h0000, 16'hFFFF, 4'd1},  // R1 erased after reset
        {1'b0, 8'h10, 16'h0040, 16'h0000, 4'd2},  // R2 arm program
        {1'b0, 8'h10, 16'h1234, 16'h0000, 4'd2},
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd2},  // R2 back in array mode
        {1'b0, 8'h00, 16'h0070, 16'h0000, 4'd6},
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd6},  // R6 status ready
        {1'b0, 8'h00, 16'h0050, 16'h0000, 4'd9},
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd9},  // R9 array mode
        {1'b0, 8'h00, 16'h0070, 16'h0000, 4'd9},
        {1'b1, 8'h00, 16'h0000, 16'h0000, 4'd9},  // R9 status zero
        {1'b0, 8'h20, 16'h0010, 16'h0000, 4'd2},  // R2 alternate code
        {1'b0, 8'h20, 16'hABCD, 16'h0000, 4'd2},
        {1'b1, 8'h20, 16'h0000, 16'hABCD, 4'd2},
        {1'b0, 8'h00, 16'h0050, 16'h0000, 4'd3},
        {1'b0, 8'h24, 16'h0020, 16'h0000, 4'd3},  // R3 erase sector 1
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd3},
        {1'b0, 8'h24, 16'h00D0, 16'h0000, 4'd3},
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd3},  // R3 status after confirm
        {1'b0, 8'h00, 16'h00FF, 16'h0000, 4'd10},
        {1'b1, 8'h20, 16'h0000, 16'hFFFF, 4'd3},  // R3 sector cleared
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd3},  // R3 other sector kept
        {1'b0, 8'h00, 16'h0090, 16'h0000, 4'd7},
        {1'b1, 8'h00, 16'h0000, 16'h0089, 4'd7},  // R7 manufacturer
        {1'b1, 8'h02, 16'h0000, 16'h0018, 4'd7},  // R7 device
        {1'b1, 8'h04, 16'h0000, 16'h0000, 4'd7},  // R7 other index
        {1'b0, 8'h00, 16'h0098, 16'h0000, 4'd8},
        {1'b1, 8'h20, 16'h0000, 16'h0051, 4'd8},  // R8 Q
        {1'b1, 8'h22, 16'h0000, 16'h0052, 4'd8},  // R8 R
        {1'b1, 8'h24, 16'h0000, 16'h0059, 4'd8},  // R8 Y
        {1'b1, 8'h4E, 16'h0000, 16'h0008, 4'd8},  // R8 size log2
        {1'b1, 8'hFE, 16'h0000, 16'h0000, 4'd8},  // R8 past table
        {1'b0, 8'h00, 16'h1234, 16'h0000, 4'd8},
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd8},  // R8 leave query
        {1'b0, 8'h00, 16'h0060, 16'h0000, 4'd5},
        {1'b0, 8'h00, 16'h0001, 16'h0000, 4'd5},
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd5},  // R5 lock done
        {1'b0, 8'h00, 16'h0060, 16'h0000, 4'd5},
        {1'b0, 8'h00, 16'h0055, 16'h0000, 4'd5},
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd5},  // R5 bad second write
        {1'b0, 8'h00, 16'h0070, 16'h0000, 4'd10},
        {1'b0, 8'h00, 16'h0033, 16'h0000, 4'd10},
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd10}, // R10 unknown code
        {1'b0, 8'h00, 16'hAB70, 16'h0000, 4'd12},
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd12}, // R12 upper bits ignored
        {1'b0, 8'h00, 16'h00FF, 16'h0000, 4'd10},
        {1'b0, 8'h30, 16'h0020, 16'h0000, 4'd3},
        {1'b0, 8'h30, 16'h0077, 16'h0000, 4'd3},
        {1'b1, 8'h10, 16'h0000, 16'h1234, 4'd3},  // R3 erase abort
        {1'b0, 8'h40, 16'h00E8, 16'h0000, 4'd4},
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd4},  // R4 status in burst
        {1'b0, 8'h40, 16'h0002, 16'h0000, 4'd4},
        {1'b0, 8'h40, 16'h1111, 16'h0000, 4'd4},
        {1'b0, 8'h42, 16'h2222, 16'h0000, 4'd4},
        {1'b0, 8'h44, 16'h3333, 16'h0000, 4'd4},
        {1'b0, 8'h00, 16'h00D0, 16'h0000, 4'd4},
        {1'b1, 8'h00, 16'h0000, 16'h0080, 4'd4},  // R4 after confirm
        {1'b0, 8'h00, 16'h00FF, 16'h0000, 4'd4},
        {1'b1, 8'h40, 16'h0000, 16'h1111, 4'd4},
        {1'b1, 8'h42, 16'h0000, 16'h2222, 4'd4},
        {1'b1, 8'h44, 16'h0000, 16'h3333, 4'd4},
        {1'b1, 8'h46, 16'h0000, 16'hFFFF, 4'd4},  // R4 no extra word
        {1'b1, 8'h00, 16'h0000, 16'hFFFF, 4'd4},  // R4 confirm not stored
        {1'b0, 8'h50, 16'h00E8, 16'h0000, 4'd4},
        {1'b0, 8'h50, 16'h0000, 16'h0000, 4'd4},
        {1'b0, 8'h50, 16'h5555, 16'h0000, 4'd4},
        {1'b0, 8'h00, 16'h0042, 16'h0000, 4'd4},
        {1'b1, 8'h50, 16'h0000, 16'h5555, 4'd4},  // R4 bad confirm aborts
        {1'b1, 8'h52, 16'h0000, 16'hFFFF, 4'd4}
    };

    logic [44:0] cur;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata at reset", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cur = VEC[i];
            if (cur[44]) begin
                bus_rd(cur[43:36], cur[19:4], $sformatf("R%0d vec%0d", cur[3:0], i));
            end else begin
                bus_wr(cur[43:36], cur[35:20]);
            end
        end

        // R11: rdata holds while no read is issued, even when the mode changes
        bus_rd(8'h40, 16'h1111, "R11 read");
        bus_wr(8'h00, 16'h0070);
        @(negedge clk);
        check("R11 hold", rdata, 16'h1111);
        bus_wr(8'h00, 16'h00FF);

        // R1: reset in mid-run restores erased array and cleared status
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rdata after reset", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(8'h40, 16'hFFFF, "R1 array erased");
        bus_wr(8'h00, 16'h0070);
        bus_rd(8'h00, 16'h0000, "R1 status zero");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule